// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block tracks loads that a processor has hoisted above earlier stores. When such an advancing load issues (a plain advanced load or the combined speculative-and-advanced form, both of which use the same insert port), the table records the destination register number and the physical address the load read. Every store that later writes memory presents its physical address on a snoop port. Any tracked entry whose 8-byte block overlaps that address is dropped.

When the program reaches the point where it needs the hoisted value, a check presents the register number and the address again. The table answers one cycle later. A hit means no overlapping store arrived and the entry was not displaced, so the speculative register value can be used. A miss tells software to redo the load. The table is fully associative. It holds one entry per destination register, and when it is full it displaces entries in round-robin order. A flush input empties it in one cycle. Address translation and the memory access itself lie outside the block.

Top module: `spec_ld_tracker`

## Requirements
- R1: After reset the table is empty: `rsp_valid` and `rsp_hit` are 0, and any check misses.
- R2: An insert in cycle t makes a check of the same register and address, issued in cycle t+1 or later, hit.
- R3: Addresses are compared on bits [63:3] (8-byte blocks). A check whose address differs only in bits [2:0] hits, and a check whose address is in another block misses.
- R4: A check hits only when the register number also matches. A check with another register number misses.
- R5: A store whose address lies in the same 8-byte block as an entry removes that entry, so a later check misses. A store to another block leaves the entry in place.
- R6: When a store and a check to the same block arrive in the same cycle, the store takes effect first and the check misses.
- R7: An insert for a register that already has an entry overwrites that entry in place, so the old address misses and the new one hits. At most one live entry exists per register.
- R8: With all 16 entries live, an insert for a new register displaces entries in round-robin order starting from slot 0. Slot 0 holds the first entry inserted after reset or flush. Every other entry stays.
- R9: `flush` empties the table in one cycle and restarts the round-robin order. A check or insert in the same cycle as a flush behaves as if the table were empty, and the insert is dropped.
- R10: `rsp_valid` is high exactly one cycle after each cycle with `chk_valid`, and `rsp_hit` is high only together with `rsp_valid`.
- R11: An insert and a store to the same block in the same cycle leave the new entry live, because the store is treated as older than the insert.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| ins_valid | input | 1 | Advancing load inserts an entry |
| ins_reg | input | 7 | Destination register of the advancing load |
| ins_addr | input | 64 | Physical address of the advancing load |
| st_valid | input | 1 | Store snoop strobe |
| st_addr | input | 64 | Physical address of the store |
| chk_valid | input | 1 | Check request |
| chk_reg | input | 7 | Register being checked |
| chk_addr | input | 64 | Physical address being checked |
| rsp_valid | output | 1 | Check response present (one cycle after request) |
| rsp_hit | output | 1 | 1 = speculative value valid, 0 = reload needed |

## Verification
Checks are issued against:
- a single tracked entry, with addresses inside and outside its block and with a wrong register number, which separates block-granular matching from exact or register-blind matching;
- stores to unrelated and overlapping blocks, alone and in the same cycle as a check or an insert, which exposes the wrong priority between a store and a lookup;
- repeated inserts to one register, and seventeen or more distinct registers, which separates in-place replacement from allocation and shows that round-robin eviction removes exactly the oldest slot;
- a flush combined with a check and with an insert, which confirms that flush dominates.

// File: rtl/spec_ld_pkg.sv
package spec_ld_pkg;
  localparam int unsigned ADDR_W   = 64;
  localparam int unsigned REG_W    = 7;
  localparam int unsigned LINE_LSB = 3;
  localparam int unsigned BLK_W    = ADDR_W - LINE_LSB;

  typedef struct packed {
    logic             live;
    logic [REG_W-1:0] rnum;
    logic [BLK_W-1:0] blk;
  } slot_t;
endpackage

// File: rtl/spec_ld_match.sv
module spec_ld_match
  import spec_ld_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter bit          USE_REG = 1'b1,
  parameter bit          USE_BLK = 1'b1
) (
  input  slot_t [ENTRIES-1:0] tab,
  input  logic  [REG_W-1:0]   key_reg,
  input  logic  [BLK_W-1:0]   key_blk,
  output logic  [ENTRIES-1:0] hit
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic reg_ok;
    logic blk_ok;
    if (USE_REG) begin : g_reg
      assign reg_ok = (tab[i].rnum == key_reg);
    end else begin : g_noreg
      assign reg_ok = 1'b1;
    end
    if (USE_BLK) begin : g_blk
      assign blk_ok = (tab[i].blk == key_blk);
    end else begin : g_noblk
      assign blk_ok = 1'b1;
    end
    assign hit[i] = tab[i].live & reg_ok & blk_ok;
  end
endmodule

// File: rtl/spec_ld_victim.sv
module spec_ld_victim #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] live,
  input  logic [ENTRIES-1:0] same_reg,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   slot,
  output logic               evict
);
  logic [IDX_W-1:0] same_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    same_idx = '0;
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (same_reg[i]) same_idx = IDX_W'(i);
      if (!live[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    evict = 1'b0;
    if (|same_reg) begin
      slot = same_idx;
    end else if (any_free) begin
      slot = free_idx;
    end else begin
      slot  = rr_ptr;
      evict = 1'b1;
    end
  end
endmodule

// File: rtl/spec_ld_tracker.sv
module spec_ld_tracker
  import spec_ld_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              ins_valid,
  input  logic [REG_W-1:0]  ins_reg,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              rsp_valid,
  output logic              rsp_hit
);
  slot_t [ENTRIES-1:0] tab_q, tab_d;
  logic  [IDX_W-1:0]   rr_q, rr_d;
  logic                rsp_valid_q, rsp_hit_q;
  logic                rsp_hit_d;
  logic                tab_we;

  logic [ENTRIES-1:0]  st_hit, chk_match, ins_same, live_q, live_post;
  logic [IDX_W-1:0]    ins_slot;
  logic                ins_evict;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) live_q[i] = tab_q[i].live;
  end

  spec_ld_match #(.ENTRIES(ENTRIES), .USE_REG(1'b0), .USE_BLK(1'b1)) u_st_cmp (
    .tab(tab_q), .key_reg(REG_W'(0)), .key_blk(st_addr[ADDR_W-1:LINE_LSB]),
    .hit(st_hit));

  spec_ld_match #(.ENTRIES(ENTRIES), .USE_REG(1'b1), .USE_BLK(1'b1)) u_chk_cmp (
    .tab(tab_q), .key_reg(chk_reg), .key_blk(chk_addr[ADDR_W-1:LINE_LSB]),
    .hit(chk_match));

  spec_ld_match #(.ENTRIES(ENTRIES), .USE_REG(1'b1), .USE_BLK(1'b0)) u_ins_cmp (
    .tab(tab_q), .key_reg(ins_reg), .key_blk(BLK_W'(0)),
    .hit(ins_same));

  logic [ENTRIES-1:0] st_kill;
  assign st_kill   = st_valid ? st_hit : '0;
  assign live_post = live_q & ~st_kill;

  spec_ld_victim #(.ENTRIES(ENTRIES)) u_victim (
    .live(live_post), .same_reg(ins_same & ~st_kill), .rr_ptr(rr_q),
    .slot(ins_slot), .evict(ins_evict));

  // next state: store snoop applied to old contents, then the insert, flush dominates
  always_comb begin
    tab_d = tab_q;
    rr_d  = rr_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (st_kill[i]) tab_d[i].live = 1'b0;
    end
    if (ins_valid) begin
      tab_d[ins_slot] = '{live: 1'b1, rnum: ins_reg, blk: ins_addr[ADDR_W-1:LINE_LSB]};
      if (ins_evict) rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
    if (flush) begin
      for (int i = 0; i < ENTRIES; i++) tab_d[i].live = 1'b0;
      rr_d = '0;
    end
  end

  assign tab_we    = flush | ins_valid | st_valid;
  assign rsp_hit_d = chk_valid & ~flush & |(chk_match & ~st_kill);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tab_q[i] <= '0;
      rr_q <= '0;
    end else if (tab_we) begin
      tab_q <= tab_d;
      rr_q  <= rr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
    end else begin
      rsp_valid_q <= chk_valid;
      rsp_hit_q   <= rsp_hit_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
endmodule

// File: rtl/spec_ld_tracker_chk.sv
module spec_ld_tracker_chk
  import spec_ld_pkg::*;
#(
  parameter int unsigned ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               st_valid,
  input logic [ADDR_W-1:0]  st_addr,
  input logic               chk_valid,
  input logic [ADDR_W-1:0]  chk_addr,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [ENTRIES-1:0] live_q,
  input logic [ENTRIES-1:0] ins_same
);
  p_rsp_follows_chk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> rsp_valid);
  p_no_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !rsp_valid);
  p_hit_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  p_store_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && st_valid && chk_addr[ADDR_W-1:LINE_LSB] == st_addr[ADDR_W-1:LINE_LSB])
    |=> !rsp_hit);
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (live_q == '0));
  p_flush_check_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && chk_valid) |=> !rsp_hit);
  p_one_per_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ins_same));
endmodule

bind spec_ld_tracker spec_ld_tracker_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .st_valid(st_valid), .st_addr(st_addr),
  .chk_valid(chk_valid), .chk_addr(chk_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .live_q(live_q), .ins_same(ins_same));

// File: tb/spec_ld_tracker_bench.sv
`timescale 1ns/1ps
module spec_ld_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush, ins_valid, st_valid, chk_valid;
  logic [6:0]  ins_reg, chk_reg;
  logic [63:0] ins_addr, st_addr, chk_addr;
  logic        rsp_valid, rsp_hit;

  int n_cmp = 0;
  int n_bad = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  spec_ld_tracker u_spec_ld_tracker (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ins_valid(ins_valid), .ins_reg(ins_reg), .ins_addr(ins_addr),
    .st_valid(st_valid), .st_addr(st_addr),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_addr(chk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit));

  task automatic note(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic go();
    @(posedge clk); #1;
    flush = 0; ins_valid = 0; st_valid = 0; chk_valid = 0;
  endtask

  task automatic ins(input logic [6:0] r, input logic [63:0] a);
    ins_valid = 1; ins_reg = r; ins_addr = a;
  endtask

  task automatic st(input logic [63:0] a);
    st_valid = 1; st_addr = a;
  endtask

  task automatic chk(input logic [6:0] r, input logic [63:0] a, input bit e, input string tag);
    chk_valid = 1; chk_reg = r; chk_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  // monitor: compare each response against the scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        note(1'b0, "R10 unexpected response", 1, 0);
      end else begin
        automatic bit    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        note(rsp_hit === e, t, int'(rsp_hit), int'(e));
      end
    end
  end

  initial begin
    #1000000;
    note(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; flush = 0; ins_valid = 0; st_valid = 0; chk_valid = 0;
    ins_reg = 0; chk_reg = 0; ins_addr = 0; st_addr = 0; chk_addr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    note(rsp_valid === 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
    note(rsp_hit === 1'b0, "R1 rsp_hit after reset", int'(rsp_hit), 0);

    go(); chk(3, 64'h100, 0, "R1 empty table misses");
    go(); ins(3, 64'h100);
    go(); chk(3, 64'h100, 1, "R2 check after insert");
    go(); chk(3, 64'h104, 1, "R3 same 8-byte block");
    go(); chk(3, 64'h108, 0, "R3 neighbouring block");
    go(); chk(4, 64'h100, 0, "R4 wrong register");
    go(); st(64'h200);
    go(); chk(3, 64'h100, 1, "R5 unrelated store keeps entry");
    go(); st(64'h107);
    go(); chk(3, 64'h100, 0, "R5 overlapping store removes entry");

    go(); ins(6, 64'h300);
    go(); st(64'h300); chk(6, 64'h300, 0, "R6 same-cycle store first");
    go(); chk(6, 64'h300, 0, "R6 entry gone afterwards");

    go(); ins(5, 64'h400);
    go(); ins(5, 64'h500);
    go(); chk(5, 64'h400, 0, "R7 old address replaced");
    go(); chk(5, 64'h500, 1, "R7 new address tracked");

    go(); ins(7, 64'h600); st(64'h600);
    go(); chk(7, 64'h600, 1, "R11 insert survives same-cycle store");

    go(); flush = 1; chk(5, 64'h500, 0, "R9 check during flush");
    go(); chk(7, 64'h600, 0, "R9 table empty after flush");
    go(); flush = 1; ins(8, 64'h700);
    go(); chk(8, 64'h700, 0, "R9 flush drops insert");

    for (int i = 0; i < 16; i++) begin
      go(); ins(7'(10 + i), 64'h1000 + 64'(8 * i));
    end
    go(); ins(40, 64'h2000);
    go(); chk(10, 64'h1000, 0, "R8 oldest evicted");
    go(); chk(11, 64'h1008, 1, "R8 second entry kept");
    go(); chk(25, 64'h1078, 1, "R8 newest prior entry kept");
    go(); chk(40, 64'h2000, 1, "R8 new entry present");
    go(); ins(41, 64'h2008);
    go(); chk(11, 64'h1008, 0, "R8 round robin advances");
    go(); chk(12, 64'h1010, 1, "R8 next slot kept");
    go(); ins(12, 64'h3000);
    go(); chk(13, 64'h1018, 1, "R7 replace when full evicts nothing");
    go(); chk(12, 64'h3000, 1, "R7 replaced entry when full");
    go(); chk(41, 64'h2008, 1, "R8 earlier eviction target kept");
    go();
    repeat (4) @(posedge clk);
    @(negedge clk);
    note(exp_q.size() == 0, "R10 responses outstanding", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule